// File: doc/BRIEF.md
# Receive Status FIFO with Special-Condition Lock

This block keeps per-character receive status in step with a receive data FIFO. Every entry holds three fields: an end-of-frame marker, the CRC error result latched at the closing flag, and a 3-bit residue code. The framing logic pushes one entry per received character. Software-side logic reads the entry at the head, which drives the status it sees, and pops it once it has been consumed.

An entry with the end-of-frame marker set raises a special receive condition when it reaches the head. In two of the four receive interrupt modes the FIFO then freezes. The head entry cannot be popped until an explicit error-reset strobe arrives, and new status keeps arriving behind it until the FIFO is full. In the other two modes the condition is still flagged but nothing freezes. Interrupt priority and vectoring are handled elsewhere.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the FIFO is empty, with `empty_o`=1, `full_o`=0, `special_cond_o`=0, `locked_o`=0, `overrun_o`=0 and all head fields 0.
- R2: Entries leave in the order they were pushed. The head outputs show the oldest entry's eof, CRC error and residue, and they read 0 while the FIFO is empty.
- R3: Depth is 3. `full_o` is high with 3 entries and `empty_o` is high with 0. A push while full and not popping is dropped and sets `overrun_o`, which stays high until `err_reset_i`.
- R4: `special_cond_o` is high exactly while the FIFO is non-empty and its head entry has eof=1.
- R5: The mode encoding is 0 = receive interrupts off, 1 = first character or special condition, 2 = every character or special condition, and 3 = special condition only. In modes 1 and 3, `locked_o` rises in the same cycle that an eof entry becomes the head.
- R6: While `locked_o` is high, pops are ignored and the head entry does not change. Pushes are still accepted until the FIFO is full.
- R7: Only `err_reset_i` unlocks the FIFO, and a mode change does not. `locked_o` falls one edge after the strobe, the same eof head does not lock again, and the next pop removes it.
- R8: In modes 0 and 2, an eof entry at the head raises `special_cond_o` but `locked_o` stays low and pops proceed.
- R9: A push and a pop in the same cycle while full and unlocked are both accepted. `full_o` stays high and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write one status entry |
| push_eof_i | input | 1 | End-of-frame marker of the entry |
| push_crc_err_i | input | 1 | Latched CRC error of the entry |
| push_residue_i | input | 3 | Latched residue code of the entry |
| pop_i | input | 1 | Remove the head entry |
| mode_i | input | 2 | Receive interrupt mode (see R5) |
| err_reset_i | input | 1 | Error-reset strobe: unlocks and clears overrun |
| head_eof_o | output | 1 | Head entry end-of-frame marker |
| head_crc_err_o | output | 1 | Head entry CRC error |
| head_residue_o | output | 3 | Head entry residue code |
| special_cond_o | output | 1 | End-of-frame entry at the head |
| locked_o | output | 1 | Head frozen until error reset |
| full_o | output | 1 | FIFO holds 3 entries |
| empty_o | output | 1 | FIFO holds no entries |
| overrun_o | output | 1 | Sticky: a push was dropped |

## Verification
Head fields, `full_o`, `empty_o` and `special_cond_o` are decoded combinationally from registered state, so they reflect a push or pop one clock edge after the request is sampled. `locked_o` rises in that same cycle, when the eof entry lands at the head, and it falls one edge after `err_reset_i`. `overrun_o` also changes one edge after the push or strobe that causes it. The bench drives every request on a falling edge and samples on the following falling edge, so each check lands exactly one edge after its stimulus. A scoreboard queue holds the expected entries, and each head is compared with the queue front before the pop is issued.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int RES_W  = 3;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    RX_IRQ_OFF       = 2'd0,
    RX_IRQ_FIRST_SPC = 2'd1,
    RX_IRQ_ALL_SPC   = 2'd2,
    RX_IRQ_SPC_ONLY  = 2'd3
  } rx_irq_mode_e;

  typedef struct packed {
    logic             eof;
    logic             crc_err;
    logic [RES_W-1:0] residue;
  } rsf_entry_t;

  localparam int ENTRY_W = $bits(rsf_entry_t);

  function automatic logic mode_locks(input logic [MODE_W-1:0] m);
    return (m == RX_IRQ_FIRST_SPC) || (m == RX_IRQ_SPC_ONLY);
  endfunction
endpackage

// File: rtl/rsf_storage.sv
module rsf_storage
  import rsf_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  rsf_entry_t wr_data_i,
  input  logic       rd_en_i,
  output rsf_entry_t head_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  rsf_entry_t [DEPTH-1:0] slots;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rsf_entry_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else if (wr_en_i && (wr_ptr_q == PTR_W'(g))) ent_q <= wr_data_i;
    end
    assign slots[g] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (rd_en_i) rd_ptr_q <= ptr_next(rd_ptr_q);
    end
  end

  assign head_o = slots[rd_ptr_q];
endmodule

// File: rtl/rsf_occupancy.sv
module rsf_occupancy #(
  parameter int DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_req_i,
  input  logic err_reset_i,
  output logic wr_en_o,
  output logic rd_en_o,
  output logic full_o,
  output logic empty_o,
  output logic overrun_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count_q;
  logic             overrun_q;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign rd_en_o = pop_req_i & ~empty_o;
  // a pop frees a slot for a push in the same cycle
  assign wr_en_o = push_i & (~full_o | rd_en_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else begin
      unique case ({wr_en_o, rd_en_o})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overrun_q <= 1'b0;
    else if (push_i && !wr_en_o) overrun_q <= 1'b1;
    else if (err_reset_i) overrun_q <= 1'b0;
  end

  assign overrun_o = overrun_q;
endmodule

// File: rtl/rsf_lock_ctrl.sv
module rsf_lock_ctrl
  import rsf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cond_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              err_reset_i,
  input  logic              pop_fire_i,
  output logic              locked_o
);
  logic lock_q;
  logic ack_q;  // current eof head already released by error reset
  logic arm;

  assign arm      = cond_i & mode_locks(mode_i) & ~ack_q;
  assign locked_o = lock_q | arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (err_reset_i) lock_q <= 1'b0;
    else if (arm) lock_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else if (pop_fire_i) ack_q <= 1'b0;
    else if (err_reset_i && cond_i) ack_q <= 1'b1;
  end
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rsf_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             push_eof_i,
  input  logic             push_crc_err_i,
  input  logic [RES_W-1:0] push_residue_i,
  input  logic             pop_i,
  input  logic [1:0]       mode_i,
  input  logic             err_reset_i,
  output logic             head_eof_o,
  output logic             head_crc_err_o,
  output logic [RES_W-1:0] head_residue_o,
  output logic             special_cond_o,
  output logic             locked_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             overrun_o
);
  rsf_entry_t wr_data, head_raw, head;
  logic wr_en, rd_en, pop_req, locked, empty, sc;

  assign wr_data = '{eof: push_eof_i, crc_err: push_crc_err_i, residue: push_residue_i};
  assign pop_req = pop_i & ~locked;

  rsf_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_req_i   (pop_req),
    .err_reset_i (err_reset_i),
    .wr_en_o     (wr_en),
    .rd_en_o     (rd_en),
    .full_o      (full_o),
    .empty_o     (empty),
    .overrun_o   (overrun_o)
  );

  rsf_storage #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .head_o    (head_raw)
  );

  assign head = empty ? '0 : head_raw;
  assign sc   = head.eof;

  rsf_lock_ctrl u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cond_i      (sc),
    .mode_i      (mode_i),
    .err_reset_i (err_reset_i),
    .pop_fire_i  (rd_en),
    .locked_o    (locked)
  );

  assign head_eof_o     = head.eof;
  assign head_crc_err_o = head.crc_err;
  assign head_residue_o = head.residue;
  assign special_cond_o = sc;
  assign locked_o       = locked;
  assign empty_o        = empty;
endmodule

// File: rtl/rsf_checker.sv
module rsf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       push_i,
  input logic       pop_i,
  input logic       err_reset_i,
  input logic       head_eof_o,
  input logic       head_crc_err_o,
  input logic [2:0] head_residue_o,
  input logic       special_cond_o,
  input logic       locked_o,
  input logic       full_o,
  input logic       empty_o,
  input logic       overrun_o
);
  assert_full_empty_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_empty_no_cond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!special_cond_o && !locked_o));

  assert_overrun_on_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && locked_o) |=> overrun_o);

  assert_locked_head_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable({head_eof_o, head_crc_err_o, head_residue_o}));

  assert_lock_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !err_reset_i) |=> locked_o);

  assert_unlock_by_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(err_reset_i));

  assert_push_pop_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full_o && !locked_o) |=> full_o);
endmodule

bind rx_status_fifo rsf_checker u_rsf_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .push_i         (push_i),
  .pop_i          (pop_i),
  .err_reset_i    (err_reset_i),
  .head_eof_o     (head_eof_o),
  .head_crc_err_o (head_crc_err_o),
  .head_residue_o (head_residue_o),
  .special_cond_o (special_cond_o),
  .locked_o       (locked_o),
  .full_o         (full_o),
  .empty_o        (empty_o),
  .overrun_o      (overrun_o)
);

// File: tb/tb_rx_status_fifo.sv
module tb_rx_status_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push = 1'b0, push_eof = 1'b0, push_crc = 1'b0;
  logic [2:0] push_res = '0;
  logic       pop = 1'b0, err_rst = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       h_eof, h_crc, sc, locked, full, empty, ovr;
  logic [2:0] h_res;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [4:0] sb_q[$];  // {eof, crc_err, residue}

  always #4 clk = ~clk;

  rx_status_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_eof_i(push_eof),
    .push_crc_err_i(push_crc), .push_residue_i(push_res), .pop_i(pop),
    .mode_i(mode), .err_reset_i(err_rst), .head_eof_o(h_eof),
    .head_crc_err_o(h_crc), .head_residue_o(h_res), .special_cond_o(sc),
    .locked_o(locked), .full_o(full), .empty_o(empty), .overrun_o(ovr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_push(input logic e, input logic c, input logic [2:0] r, input bit accept);
    push = 1'b1; push_eof = e; push_crc = c; push_res = r;
    tick();
    push = 1'b0;
    if (accept) sb_q.push_back({e, c, r});
  endtask

  // monitor side: compare head with scoreboard front, then pop
  task automatic pop_check(input string tag, input bit accept);
    chk(tag, {3'b0, h_eof, h_crc, h_res}, {3'b0, sb_q[0]});
    pop = 1'b1;
    tick();
    pop = 1'b0;
    if (accept) void'(sb_q.pop_front());
  endtask

  task automatic pulse_err_reset();
    err_rst = 1'b1;
    tick();
    err_rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", {7'b0, empty}, 8'd1);
    chk("R1 full", {7'b0, full}, 8'd0);
    chk("R1 flags", {5'b0, sc, locked, ovr}, 8'd0);
    chk("R1 R2 head zero", {3'b0, h_eof, h_crc, h_res}, 8'd0);

    // non-locking mode: order, full, overrun
    mode = 2'd2;
    do_push(0, 0, 3'd1, 1);
    do_push(0, 1, 3'd2, 1);
    do_push(0, 0, 3'd3, 1);
    chk("R3 full at depth", {6'b0, full, empty}, 8'b10);
    do_push(0, 0, 3'd7, 0);
    chk("R3 overrun on drop", {7'b0, ovr}, 8'd1);
    chk("R2 head oldest", {3'b0, h_eof, h_crc, h_res}, {3'b0, sb_q[0]});
    // R9 simultaneous push and pop while full
    push = 1'b1; push_eof = 1'b0; push_crc = 1'b0; push_res = 3'd4; pop = 1'b1;
    tick();
    push = 1'b0; pop = 1'b0;
    void'(sb_q.pop_front());
    sb_q.push_back(5'b00100);
    chk("R9 still full", {7'b0, full}, 8'd1);
    chk("R9 head advanced", {5'b0, h_res}, 8'd2);
    chk("R3 overrun sticky", {7'b0, ovr}, 8'd1);
    pulse_err_reset();
    chk("R3 overrun cleared", {7'b0, ovr}, 8'd0);
    pop_check("R2 order a", 1);
    pop_check("R2 order b", 1);
    pop_check("R2 R9 order c", 1);
    chk("R2 empty head zero", {2'b0, empty, h_eof, h_crc, h_res}, 8'b00100000);

    // R8 mode 2: flagged, no lock
    do_push(1, 1, 3'd5, 1);
    chk("R4 R8 cond no lock", {6'b0, sc, locked}, 8'b10);
    pop_check("R8 pop proceeds", 1);
    chk("R8 emptied", {6'b0, empty, sc}, 8'b10);

    // R5 R6 R7 mode 3
    mode = 2'd3;
    do_push(0, 0, 3'd1, 1);
    do_push(1, 1, 3'd6, 1);
    do_push(0, 0, 3'd2, 1);
    chk("R4 data head no cond", {6'b0, sc, locked}, 8'b00);
    pop_check("R2 before eof", 1);
    chk("R5 lock on eof head", {6'b0, sc, locked}, 8'b11);
    pop_check("R6 pop ignored", 0);
    chk("R6 head stable", {3'b0, h_eof, h_crc, h_res}, {3'b0, 5'b11110});
    do_push(0, 1, 3'd3, 1);
    chk("R6 push while locked", {7'b0, full}, 8'd1);
    do_push(0, 0, 3'd0, 0);
    chk("R3 R6 overrun locked", {7'b0, ovr}, 8'd1);
    mode = 2'd0;
    tick();
    chk("R7 mode change keeps lock", {7'b0, locked}, 8'd1);
    mode = 2'd3;
    pulse_err_reset();
    chk("R7 unlocked after reset", {6'b0, sc, locked}, 8'b10);
    tick();
    chk("R7 no relock same head", {7'b0, locked}, 8'd0);
    pop_check("R7 pop eof after reset", 1);
    chk("R7 next head", {5'b0, h_res}, 8'd2);
    pop_check("R2 drain a", 1);
    pop_check("R2 drain b", 1);
    pulse_err_reset();

    // R5 mode 1 with eof landing on empty FIFO
    mode = 2'd1;
    do_push(1, 0, 3'd4, 1);
    chk("R5 mode1 locks", {7'b0, locked}, 8'd1);
    pulse_err_reset();
    pop_check("R7 mode1 release", 1);
    chk("R7 mode1 empty", {6'b0, empty, locked}, 8'b10);

    // R8 mode 0
    mode = 2'd0;
    do_push(1, 0, 3'd3, 1);
    chk("R8 mode0 no lock", {6'b0, sc, locked}, 8'b10);
    pop_check("R8 mode0 pop", 1);
    chk("R8 mode0 empty", {7'b0, empty}, 8'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule